// File: doc/BRIEF.md
# Register File with Left-Shift Datapath

This block is a small synchronous datapath built around a bank of four 4-bit registers. Two read addresses select two registers whose contents appear combinationally on two read outputs. The first read value serves as a shift amount and the second as the operand of a combinational left-shift unit. The unit shifts zeros in from the right and keeps only the low four bits.

The storage is clocked by an update strobe. On each rising edge of the strobe, one destination register, chosen by a write address, is loaded. A source-select input picks what is loaded: either an externally supplied 4-bit value or the shift result. An asynchronous clear input zeroes the whole bank and wins over any update edge that occurs while it is high.

All four register contents, both read values and the shift result are driven on outputs at all times. This lets a surrounding display or test harness watch the datapath directly.

Top module: `shreg_bank`

## Requirements
- R1: The bank holds four 4-bit registers addressed 0 to 3. Register i is visible at all times on `bank_view[4*i+3:4*i]`.
- R2: While `clr` is high, every register reads zero without waiting for an update edge. An update edge that arrives while `clr` is high leaves every register at zero.
- R3: On a rising edge of `upd_clk` with `clr` low, only the register selected by `wr_addr` may change. The other three keep their values.
- R4: With `src_sel` = 0, the rising edge of `upd_clk` stores `usr_val` into register `wr_addr`.
- R5: With `src_sel` = 1, the rising edge of `upd_clk` stores the current `shf_out` into register `wr_addr`.
- R6: `shf_out` equals `rd_b_val` shifted left by `rd_a_val` positions, with zero fill and truncation to 4 bits. Any shift amount from 4 to 15 gives 4'b0000.
- R7: `rd_a_val` and `rd_b_val` show the registers chosen by `rd_a_addr` and `rd_b_addr` combinationally. When a read address selects the register being written, the read output shows the old value until the update edge and the new value after it.
- R8: Starting from a clear bank, the following steps leave register 2 at 4'b1100, register 0 at 2, register 1 at 7 and register 3 at 6:
  - store 6 into register 3 from the external input;
  - store 2 into register 0 from the external input;
  - store 7 into register 1 from the external input;
  - store the shift result with `rd_a_addr`=0, `rd_b_addr`=1 and `wr_addr`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| upd_clk | input | 1 | Update strobe. Its rising edge writes the destination register. |
| clr | input | 1 | Asynchronous clear of all registers, active high. |
| src_sel | input | 1 | Write source: 0 selects the external value, 1 selects the shift result. |
| usr_val | input | 4 | External value to be written. |
| rd_a_addr | input | 2 | Address of the register that supplies the shift amount. |
| rd_b_addr | input | 2 | Address of the register that supplies the shift operand. |
| wr_addr | input | 2 | Destination register address. |
| bank_view | output | 16 | All four register contents; register i is in bits 4i+3 down to 4i. |
| rd_a_val | output | 4 | Contents of the register at `rd_a_addr`. |
| rd_b_val | output | 4 | Contents of the register at `rd_b_addr`. |
| shf_out | output | 4 | `rd_b_val` shifted left by `rd_a_val`, truncated to 4 bits. |

## Verification
Two functions can fall in the same cycle here: the asynchronous clear and an update edge. The bench raises `clr`, sets up a write whose data is non-zero, and then pulses `upd_clk` while `clr` is still high. It judges the result by reading all four registers on `bank_view` after the edge and after `clr` drops; every register must be zero. A second case in the same cycle is a write to a register that is also being read. The bench samples the read output just before the edge, where it must show the old value, and again after the edge, where it must show the new one.

// File: rtl/shreg_bank.sv
module shreg_bank #(
  parameter int W = 4,
  parameter int N = 4,
  localparam int AW = $clog2(N)
) (
  input  logic            upd_clk,
  input  logic            clr,
  input  logic            src_sel,
  input  logic [W-1:0]    usr_val,
  input  logic [AW-1:0]   rd_a_addr,
  input  logic [AW-1:0]   rd_b_addr,
  input  logic [AW-1:0]   wr_addr,
  output logic [N*W-1:0]  bank_view,
  output logic [W-1:0]    rd_a_val,
  output logic [W-1:0]    rd_b_val,
  output logic [W-1:0]    shf_out
);
  localparam logic [W-1:0] SHIFT_LIM = W[W-1:0];

  logic [W-1:0] regs [N];
  logic [W-1:0] wdata;

  assign rd_a_val = regs[rd_a_addr];
  assign rd_b_val = regs[rd_b_addr];
  assign shf_out  = (rd_a_val >= SHIFT_LIM) ? '0 : (rd_b_val << rd_a_val);
  assign wdata    = src_sel ? shf_out : usr_val;

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge upd_clk or posedge clr) begin
      if (clr)
        regs[i] <= '0;
      else if (wr_addr == AW'(i))
        regs[i] <= wdata;
    end
    assign bank_view[i*W +: W] = regs[i];
  end
endmodule

// File: rtl/shreg_bank_chk.sv
module shreg_bank_chk #(
  parameter int W = 4,
  parameter int N = 4,
  localparam int AW = $clog2(N)
) (
  input logic            upd_clk,
  input logic            clr,
  input logic            src_sel,
  input logic [W-1:0]    usr_val,
  input logic [AW-1:0]   wr_addr,
  input logic [N*W-1:0]  bank_view,
  input logic [W-1:0]    rd_a_val,
  input logic [W-1:0]    rd_b_val,
  input logic [W-1:0]    shf_out
);
  always @(posedge upd_clk) begin
    if (clr) AST_CLEAR_WINS: assert (bank_view == '0); // R2
  end

  AST_SHIFT_ZERO_FILL: assert property (@(posedge upd_clk) disable iff (clr)
    (rd_a_val != '0) |-> (shf_out[0] == 1'b0)); // R6

  AST_SHIFT_IDENT: assert property (@(posedge upd_clk) disable iff (clr)
    (rd_a_val == '0) |-> (shf_out == rd_b_val)); // R6

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_USER_WRITE: assert property (@(posedge upd_clk) disable iff (clr)
      (wr_addr == AW'(i) && !src_sel) |=> (bank_view[i*W +: W] == $past(usr_val))); // R4
    AST_SHIFT_WRITE: assert property (@(posedge upd_clk) disable iff (clr)
      (wr_addr == AW'(i) && src_sel) |=> (bank_view[i*W +: W] == $past(shf_out))); // R5
    AST_OTHERS_HOLD: assert property (@(posedge upd_clk) disable iff (clr)
      (wr_addr != AW'(i)) |=> $stable(bank_view[i*W +: W])); // R3
  end
endmodule

bind shreg_bank shreg_bank_chk #(.W(W), .N(N)) u_chk (
  .upd_clk(upd_clk), .clr(clr), .src_sel(src_sel), .usr_val(usr_val),
  .wr_addr(wr_addr), .bank_view(bank_view), .rd_a_val(rd_a_val),
  .rd_b_val(rd_b_val), .shf_out(shf_out)
);

// File: tb/shreg_bank_tb.sv
module shreg_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        upd_clk = 1'b0;
  logic        clr = 1'b1;
  logic        src_sel = 1'b0;
  logic [3:0]  usr_val = '0;
  logic [1:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [15:0] bank_view;
  logic [3:0]  rd_a_val, rd_b_val, shf_out;

  int n_chk = 0, n_fail = 0;
  logic [3:0] mdl [4];
  bit done = 0;

  shreg_bank u_dut (
    .upd_clk(upd_clk), .clr(clr), .src_sel(src_sel), .usr_val(usr_val),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr), .wr_addr(wr_addr),
    .bank_view(bank_view), .rd_a_val(rd_a_val), .rd_b_val(rd_b_val),
    .shf_out(shf_out)
  );

  function automatic logic [3:0] ref_shift(logic [3:0] amt, logic [3:0] opnd);
    int v;
    if (amt >= 4) return 4'h0;
    v = int'(opnd) * (1 << amt);
    return 4'(v % 16);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bank(string req);
    check(req, bank_view, {mdl[3], mdl[2], mdl[1], mdl[0]});
  endtask

  task automatic pulse;
    #(CLK_PERIOD/2) upd_clk = 1'b1;
    #(CLK_PERIOD/2) upd_clk = 1'b0;
    #1;
  endtask

  task automatic put_user(logic [1:0] a, logic [3:0] v);
    src_sel = 1'b0; wr_addr = a; usr_val = v;
    pulse();
    mdl[a] = v;
  endtask

  task automatic t_reset;
    #(CLK_PERIOD) ;
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    check_bank("R2 clear at start");
    clr = 1'b0; #1;
    check_bank("R1 bank zero after clear release");
  endtask

  task automatic t_example;
    put_user(2'd3, 4'd6);
    put_user(2'd0, 4'd2);
    put_user(2'd1, 4'd7);
    check_bank("R4 user writes");
    rd_a_addr = 2'd0; rd_b_addr = 2'd1; wr_addr = 2'd2; src_sel = 1'b1; #1;
    check("R6 example shift", 16'(shf_out), 16'h000C);
    pulse();
    mdl[2] = 4'b1100;
    check("R8 example r2", 16'(bank_view[11:8]), 16'h000C);
    check_bank("R8 example bank");
  endtask

  task automatic t_read_ports;
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        rd_a_addr = 2'(a); rd_b_addr = 2'(b); #1;
        check("R7 read port a", 16'(rd_a_val), 16'(mdl[a]));
        check("R7 read port b", 16'(rd_b_val), 16'(mdl[b]));
      end
    end
  endtask

  task automatic t_all_shifts;
    logic [3:0] ops [3] = '{4'h1, 4'hF, 4'h9};
    for (int k = 0; k < 3; k++) begin
      for (int a = 0; a < 16; a++) begin
        put_user(2'd0, 4'(a));
        put_user(2'd1, ops[k]);
        src_sel = 1'b1; rd_a_addr = 2'd0; rd_b_addr = 2'd1; wr_addr = 2'd2; #1;
        check("R6 shift output", 16'(shf_out), 16'(ref_shift(4'(a), ops[k])));
        pulse();
        mdl[2] = ref_shift(4'(a), ops[k]);
        check_bank("R5 shift written, R3 others held");
      end
    end
  endtask

  task automatic t_self_shift;
    put_user(2'd3, 4'd1);
    src_sel = 1'b1; rd_a_addr = 2'd3; rd_b_addr = 2'd3; wr_addr = 2'd3; #1;
    check("R7 old value before edge", 16'(rd_b_val), 16'h0001);
    pulse();
    mdl[3] = 4'd2;
    check("R7 new value after edge", 16'(rd_b_val), 16'h0002);
    check_bank("R5 self shift");
  endtask

  task automatic t_clear_vs_update;
    put_user(2'd1, 4'hA);
    #2 clr = 1'b1; #1;
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    check_bank("R2 async clear without edge");
    src_sel = 1'b0; wr_addr = 2'd1; usr_val = 4'h5;
    pulse();
    check_bank("R2 clear beats update edge");
    clr = 1'b0; #1;
    check_bank("R2 bank zero after release");
    put_user(2'd2, 4'h3);
    check_bank("R4 write after clear");
  endtask

  initial begin
    t_reset();
    t_example();
    t_read_ports();
    t_all_shifts();
    t_self_shift();
    t_read_ports();
    t_clear_vs_update();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule